// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit With Condition Flags

This block is the purely combinational datapath core of a small 8-bit processor. Each evaluation takes an operation code, two operand bytes and the current carry and decimal-mode flags. It returns a result byte, a new carry, negative, zero and overflow flags, and a write-result strobe. The strobe tells the register file whether the result byte should be stored.

The unit covers binary add and subtract through the carry, compare, the three bitwise logic operations, zero-fill shifts, rotates through the carry, and increment and decrement by one. Decimal-mode arithmetic is not implemented. When add or subtract is requested with the decimal flag set, the block raises `unsupported` and withholds the write, so the surrounding control logic can trap the request. Undefined operation codes are reported the same way.

Opcode encoding on `op`: 0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5 XOR, 6 shift left, 7 shift right, 8 rotate left, 9 rotate right, 10 increment, 11 decrement, 12 to 15 undefined.

Top module: `alu8_flags`

## Requirements
- R1: Add (op 0) returns the low byte of a + b + c_in. c_out is 1 when that sum exceeds 255.
- R2: Subtract (op 1) returns the low byte of a - b - (1 - c_in). c_out is 1 when no borrow occurs, that is when a >= b + (1 - c_in).
- R3: Compare (op 2) sets c_out, n_out and z_out exactly as subtract does with the carry forced to 1, whatever c_in is. wr_en is 0.
- R4: AND, OR and XOR (ops 3, 4, 5) return a&b, a|b and a^b. c_out equals c_in.
- R5: Shift left (op 6) returns a<<1 with 0 entering bit 0, and c_out = a[7]. Shift right (op 7) returns a>>1 with 0 entering bit 7, and c_out = a[0].
- R6: Rotate left (op 8) puts c_in into bit 0 and sends a[7] to c_out. Rotate right (op 9) puts c_in into bit 7 and sends a[0] to c_out.
- R7: Increment (op 10) and decrement (op 11) act on a and wrap modulo 256 (0xFF+1 gives 0x00, 0x00-1 gives 0xFF). c_out equals c_in.
- R8: For every defined operation, n_out is bit 7 of the computed byte and z_out is 1 exactly when that byte is zero. This includes the difference produced by compare.
- R9: v_out is 1 for add when a and b share a sign bit that differs from the result's sign bit. For subtract and compare the same rule is applied with ~b in place of b. v_out is 0 for all other operations.
- R10: Add or subtract with d_flag = 1 sets unsupported = 1 and wr_en = 0. d_flag has no effect on any other operation.
- R11: Undefined codes 12 to 15 set unsupported = 1 and wr_en = 0, and pass c_in to c_out. Every other defined case gives unsupported = 0 and wr_en = 1, except compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code (encoding above) |
| a | input | 8 | First operand; the only operand for shifts, rotates, increment and decrement |
| b | input | 8 | Second operand |
| c_in | input | 1 | Current carry flag |
| d_flag | input | 1 | Current decimal-mode flag |
| result | output | 8 | Computed byte |
| c_out | output | 1 | New carry flag |
| n_out | output | 1 | New negative flag |
| z_out | output | 1 | New zero flag |
| v_out | output | 1 | New overflow flag |
| wr_en | output | 1 | Store the result byte |
| unsupported | output | 1 | Request cannot be executed |

## Verification
The block holds no state. Any fault in its operand selection, carry chain or flag logic therefore appears at the ports in the same evaluation that presents the offending inputs, and it is visible within that cycle. The most telling cases are carry-chain errors at the 0xFF/0x00 boundary, a carry that leaks into increment, decrement or the logic operations, and a compare that writes or reads c_in. Sign-boundary operands such as 0x7F and 0x80 expose mistakes in the overflow rule.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  input  logic         d_flag,
  output logic [W-1:0] result,
  output logic         c_out,
  output logic         n_out,
  output logic         z_out,
  output logic         v_out,
  output logic         wr_en,
  output logic         unsupported
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_CMP = 4'd2,
    OP_AND = 4'd3, OP_OR = 4'd4, OP_XOR = 4'd5, OP_SHL = 4'd6, OP_SHR = 4'd7,
    OP_ROL = 4'd8, OP_ROR = 4'd9, OP_INC = 4'd10, OP_DEC = 4'd11;
  localparam int MSB = W - 1;

  logic         is_arith, is_sub;
  logic [W-1:0] b_eff;
  logic         cin_eff;
  logic [W:0]   sum;
  logic         defined;

  assign is_sub   = (op == OP_SUB) || (op == OP_CMP);
  assign is_arith = (op == OP_ADD) || is_sub;
  assign b_eff    = is_sub ? ~b : b;
  assign cin_eff  = (op == OP_CMP) ? 1'b1 : c_in;
  assign sum      = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin_eff};
  assign defined  = op <= OP_DEC;

  always_comb begin
    result = '0;
    c_out  = c_in;
    unique case (op)
      OP_ADD, OP_SUB, OP_CMP: begin result = sum[W-1:0]; c_out = sum[W]; end
      OP_AND: result = a & b;
      OP_OR:  result = a | b;
      OP_XOR: result = a ^ b;
      OP_SHL: begin result = {a[W-2:0], 1'b0};  c_out = a[MSB]; end
      OP_SHR: begin result = {1'b0, a[W-1:1]};  c_out = a[0];   end
      OP_ROL: begin result = {a[W-2:0], c_in};  c_out = a[MSB]; end
      OP_ROR: begin result = {c_in, a[W-1:1]};  c_out = a[0];   end
      OP_INC: result = a + 1'b1;
      OP_DEC: result = a - 1'b1;
      default: ;
    endcase
  end

  assign n_out = result[MSB];
  assign z_out = (result == '0);
  assign v_out = is_arith && (a[MSB] == b_eff[MSB]) && (result[MSB] != a[MSB]);
  assign unsupported = !defined || (d_flag && (op == OP_ADD || op == OP_SUB));
  assign wr_en = !unsupported && (op != OP_CMP);

  always_comb begin
    a_r3_cmp_no_write: assert (!(op == OP_CMP && wr_en));
    a_r4_logic_keeps_carry: assert (!(op inside {OP_AND, OP_OR, OP_XOR}) || c_out == c_in);
    a_r7_incdec_keeps_carry: assert (!(op inside {OP_INC, OP_DEC}) || c_out == c_in);
    a_r9_no_overflow_outside_arith: assert (is_arith || !v_out);
    a_r10_unsupported_blocks_write: assert (!(unsupported && wr_en));
    a_r6_rol_carry_into_lsb: assert (op != OP_ROL || result[0] == c_in);
  end
endmodule

// File: tb/alu8_flags_test.sv
module alu8_flags_test;
  logic clk = 0;
  always #5 clk = ~clk;

  logic [3:0] op;
  logic [7:0] a, b, result;
  logic c_in, d_flag, c_out, n_out, z_out, v_out, wr_en, unsupported;
  int errors = 0, checks = 0;
  bit done = 0;

  alu8_flags uut (.op(op), .a(a), .b(b), .c_in(c_in), .d_flag(d_flag),
    .result(result), .c_out(c_out), .n_out(n_out), .z_out(z_out),
    .v_out(v_out), .wr_en(wr_en), .unsupported(unsupported));

  // expected {result, c, n, z, v, wr, unsup}
  function automatic logic [13:0] model(input int o, input int x, input int y,
                                        input bit c, input bit d);
    int r; bit co, v, wr, un;
    r = 0; co = c; v = 0; wr = 1; un = 0;
    case (o)
      0: begin r = x + y + c; co = r > 255; v = ((x ^ y) < 128) && (((x ^ r) & 128) != 0); un = d; end
      1, 2: begin
        int ci; ci = (o == 2) ? 1 : int'(c);
        r = x - y - (1 - ci); co = r >= 0;
        v = (((x ^ y) & 128) != 0) && ((((x ^ r) & 128)) != 0);
        if (o == 1) un = d; else wr = 0;
      end
      3: r = x & y;
      4: r = x | y;
      5: r = x ^ y;
      6: begin r = x * 2; co = x >= 128; end
      7: begin r = x / 2; co = x % 2; end
      8: begin r = x * 2 + c; co = x >= 128; end
      9: begin r = x / 2 + (c ? 128 : 0); co = x % 2; end
      10: r = x + 1;
      11: r = x - 1;
      default: begin un = 1; r = 0; end
    endcase
    r = r & 255;
    if (un) wr = 0;
    return {r[7:0], co, r >= 128, r == 0, v, wr, un};
  endfunction

  function automatic string tag(input int o, input bit d);
    if (o >= 12) return "R11";
    if (d && o <= 1) return "R10";
    case (o)
      0: return "R1/R8/R9";
      1: return "R2/R8/R9";
      2: return "R3/R8/R9";
      3, 4, 5: return "R4/R8";
      6, 7: return "R5/R8";
      8, 9: return "R6/R8";
      default: return "R7/R8";
    endcase
  endfunction

  task automatic apply(input int o, input int x, input int y, input bit c, input bit d);
    logic [13:0] exp, act;
    @(negedge clk);
    op = o[3:0]; a = x[7:0]; b = y[7:0]; c_in = c; d_flag = d;
    #2;
    exp = model(o, x, y, c, d);
    act = {result, c_out, n_out, z_out, v_out, wr_en, unsupported};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h c=%0d d=%0d actual=%h expected=%h",
               tag(o, d), o, x, y, c, d, act, exp);
    end
  endtask

  initial begin
    int seed;
    seed = 32'h1bad5eed;
    void'($urandom(seed));
    op = 0; a = 0; b = 0; c_in = 0; d_flag = 0;
    repeat (2) @(posedge clk);
    apply(0, 0, 0, 0, 0);                 // R1 R8 initial zero inputs
    apply(0, 8'hFF, 8'h00, 1, 0);         // R1 carry out, zero
    apply(0, 8'h7F, 8'h01, 0, 0);         // R9 positive overflow
    apply(0, 8'h80, 8'h80, 0, 0);         // R9 negative overflow
    apply(1, 8'h00, 8'h01, 1, 0);         // R2 borrow
    apply(1, 8'h05, 8'h05, 0, 0);         // R2 borrow from c_in=0
    apply(1, 8'h80, 8'h01, 1, 0);         // R9 sub overflow
    apply(2, 8'h10, 8'h10, 0, 0);         // R3 c_in ignored
    apply(2, 8'h10, 8'h20, 1, 1);         // R3 d_flag ignored
    apply(3, 8'hF0, 8'h0F, 1, 0);         // R4 zero result, carry kept
    apply(6, 8'h80, 8'h00, 0, 0);         // R5
    apply(7, 8'h01, 8'h00, 1, 0);         // R5
    apply(8, 8'h80, 8'h00, 1, 0);         // R6
    apply(9, 8'h01, 8'h00, 1, 0);         // R6
    apply(10, 8'hFF, 8'h00, 0, 0);        // R7 wrap up
    apply(11, 8'h00, 8'h00, 1, 0);        // R7 wrap down
    apply(0, 8'h12, 8'h34, 0, 1);         // R10
    apply(1, 8'h12, 8'h34, 1, 1);         // R10
    apply(5, 8'h12, 8'h34, 1, 1);         // R10 no effect on logic
    for (int k = 12; k < 16; k++) apply(k, 8'h55, 8'hAA, k[0], 0); // R11
    for (int i = 0; i < 3000; i++)
      apply($urandom % 16, $urandom % 256, $urandom % 256, $urandom % 2,
            ($urandom % 4) == 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule